// File: doc/BRIEF.md
# Variable-Length Instruction Pre-Decoder

This block sits on the instruction-cache fill path. When a raw 16-byte line arrives, it walks the instruction stream from the entry offset of the line and marks the first byte and the last byte of every instruction. It flags each instruction whose opcode is a branch and gives that branch a 2-bit class. These annotations are meant to be written into the cache next to the line. The walk takes several cycles. A one-cycle done pulse tells the fill logic when the annotated line is ready.

On the fetch side, a separate combinational extractor takes a fetched line, its stored start and end marks, and a fetch offset. It hands up to three byte-aligned instructions to parallel decoders in the same cycle. It relies only on the stored marks and decodes no lengths serially.

The toy encoding works as follows. The top two bits of an instruction's first byte, plus one, give its length of 1 to 4 bytes. First-byte values 0xE0 to 0xEF are branches.

The fill side is a three-state machine:
- `S_IDLE` waits for a request. It moves to `S_SCAN` on `fill_valid`; this is the accept edge.
- `S_SCAN` handles one 4-byte chunk per cycle. After the fourth chunk it moves to `S_DONE`.
- `S_DONE` drives `fill_done` for one cycle and always returns to `S_IDLE`.

Top module: `ilen_predecode`

## Requirements
- R1: After reset, `fill_done` is 0 and all annotation outputs (`ann_start`, `ann_end`, `ann_branch`, `ann_btype`, `ann_incomplete`) are 0.
- R2: `fill_done` is a single-cycle pulse. It is high in the cycle that follows the fourth rising edge after the accept edge, and only in that cycle.
- R3: `fill_valid` is ignored while a scan or its done cycle is in progress. The result belongs to the accepted line, and no extra done pulse follows.
- R4: The first instruction starts at `fill_offset`. Each later instruction starts at the previous start plus its length, where length = (first byte bits [7:6]) + 1. Bit s of `ann_start` marks a start byte s. Bit (s+length-1) of `ann_end` marks the last byte when that byte lies within the line.
- R5: Bytes below `fill_offset` carry no start or end mark.
- R6: An instruction whose last byte would fall past byte 15 gets a start mark but no end mark, and `ann_incomplete` is set to 1.
- R7: `ann_branch[s]` is 1 only for an instruction starting at byte s whose first byte is 0xE0 to 0xEF. All other bits are 0.
- R8: For a branch starting at byte s, `ann_btype[2s+1:2s]` equals its first byte's bits [1:0]: 00 conditional, 01 unconditional direct, 10 call, 11 return or indirect. For non-branches the field is 00.
- R9: The extractor considers instructions whose start mark is at or after `fetch_offset` and whose end mark is in the line. It fills them, in line order, into slots 0, 1, 2. Slot k holds its bytes at `slot_data[32k+8j +: 8]` for byte j of the instruction, with unused bytes 0. `slot_len[3k +: 3]` holds the length, 1 to 4.
- R10: Valid slots are packed from slot 0 upward. Fewer than three are valid when fewer complete instructions exist, and an instruction without an end mark is never emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_valid | input | 1 | Request to pre-decode `fill_line` |
| fill_line | input | 128 | Raw line, byte i at bits [8i+7:8i] |
| fill_offset | input | 4 | Entry byte of the line |
| fill_done | output | 1 | One-cycle pulse: annotation ready |
| ann_start | output | 16 | Per-byte start marks |
| ann_end | output | 16 | Per-byte end marks |
| ann_branch | output | 16 | Branch flag at each branch start byte |
| ann_btype | output | 32 | 2-bit branch class per byte |
| ann_incomplete | output | 1 | Last instruction runs past the line |
| fetch_line | input | 128 | Fetched line bytes |
| fetch_start | input | 16 | Stored start marks of the fetched line |
| fetch_end | input | 16 | Stored end marks of the fetched line |
| fetch_offset | input | 4 | Fetch entry byte |
| slot_valid | output | 3 | Valid bit per aligned slot |
| slot_len | output | 9 | 3-bit length per slot |
| slot_data | output | 96 | 32 bits of aligned bytes per slot |

## Verification
Properties are checked on every cycle:
- the done pulse is one cycle long and arrives at a fixed distance from the accept edge;
- at done, the number of end marks plus the incomplete flag equals the number of start marks;
- at done, no mark sits below the entry offset, and branch flags sit only on start bytes;
- extractor slots are always packed and each valid slot has a legal length.

Only the directed scenarios can show the following:
- that marks land on exactly the right bytes for each length and offset mix;
- that branch classes follow the opcode's low bits;
- that a request during a scan is dropped;
- that the extractor picks the right three instructions and the right bytes.

// File: rtl/ilpd_pkg.sv
package ilpd_pkg;
    localparam int LINE_BYTES  = 16;
    localparam int CHUNK_BYTES = 4;
    localparam int N_SLOTS     = 3;
    localparam int MAX_LEN     = 4;
    localparam int N_CHUNKS    = LINE_BYTES / CHUNK_BYTES;
    localparam int POS_W       = $clog2(LINE_BYTES);
    localparam int CHK_W       = $clog2(N_CHUNKS);
    localparam int SCAN_W      = POS_W + 1;
    localparam int LEN_W       = 3;
    localparam int LINE_W      = LINE_BYTES * 8;
    localparam int SLOT_W      = MAX_LEN * 8;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_SCAN = 2'd1,
        S_DONE = 2'd2
    } fill_state_e;

    // Length field lives in the top two bits of the first byte.
    function automatic logic [LEN_W-1:0] op_len(input logic [7:0] b);
        return {1'b0, b[7:6]} + LEN_W'(1);
    endfunction

    function automatic logic op_is_branch(input logic [7:0] b);
        return b[7:4] == 4'hE;
    endfunction
endpackage

// File: rtl/ilpd_chunk_scan.sv
module ilpd_chunk_scan
    import ilpd_pkg::*;
(
    input  logic [LINE_W-1:0]       line,
    input  logic [CHK_W-1:0]        chunk,
    input  logic [SCAN_W-1:0]       pos_in,
    output logic [LINE_BYTES-1:0]   start_set,
    output logic [LINE_BYTES-1:0]   end_set,
    output logic [LINE_BYTES-1:0]   br_set,
    output logic [2*LINE_BYTES-1:0] type_set,
    output logic                    overrun,
    output logic [SCAN_W-1:0]       pos_out
);
    logic [SCAN_W-1:0] p;
    logic [SCAN_W-1:0] idx;
    logic [SCAN_W-1:0] last;
    logic [7:0]        b;
    logic [LEN_W-1:0]  len;

    // Chained walk across the bytes of one chunk.
    always_comb begin
        p         = pos_in;
        start_set = '0;
        end_set   = '0;
        br_set    = '0;
        type_set  = '0;
        overrun   = 1'b0;
        idx       = '0;
        last      = '0;
        b         = '0;
        len       = '0;
        for (int j = 0; j < CHUNK_BYTES; j++) begin
            idx = SCAN_W'(int'(chunk) * CHUNK_BYTES + j);
            if (idx == p) begin
                b    = line[{idx[POS_W-1:0], 3'b000} +: 8];
                len  = op_len(b);
                last = idx + SCAN_W'(len) - SCAN_W'(1);
                start_set[idx[POS_W-1:0]] = 1'b1;
                if (last < SCAN_W'(LINE_BYTES))
                    end_set[last[POS_W-1:0]] = 1'b1;
                else
                    overrun = 1'b1;
                if (op_is_branch(b)) begin
                    br_set[idx[POS_W-1:0]] = 1'b1;
                    type_set[{idx[POS_W-1:0], 1'b0} +: 2] = b[1:0];
                end
                p = idx + SCAN_W'(len);
            end
        end
        pos_out = p;
    end
endmodule

// File: rtl/ilpd_fill_fsm.sv
module ilpd_fill_fsm
    import ilpd_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    fill_valid,
    input  logic [LINE_W-1:0]       fill_line,
    input  logic [POS_W-1:0]        fill_offset,
    output logic                    fill_done,
    output logic [LINE_BYTES-1:0]   ann_start,
    output logic [LINE_BYTES-1:0]   ann_end,
    output logic [LINE_BYTES-1:0]   ann_branch,
    output logic [2*LINE_BYTES-1:0] ann_btype,
    output logic                    ann_incomplete
);
    fill_state_e state, nxt;
    logic [CHK_W-1:0]        chunk_q;
    logic [SCAN_W-1:0]       pos_q;
    logic [LINE_W-1:0]       line_q;
    logic [POS_W-1:0]        off_q;
    logic [LINE_BYTES-1:0]   start_q, end_q, br_q;
    logic [2*LINE_BYTES-1:0] type_q;
    logic                    inc_q;

    logic [LINE_BYTES-1:0]   s_set, e_set, b_set;
    logic [2*LINE_BYTES-1:0] t_set;
    logic                    ovr;
    logic [SCAN_W-1:0]       pos_nx;
    logic                    last_chunk;

    ilpd_chunk_scan u_scan (
        .line      (line_q),
        .chunk     (chunk_q),
        .pos_in    (pos_q),
        .start_set (s_set),
        .end_set   (e_set),
        .br_set    (b_set),
        .type_set  (t_set),
        .overrun   (ovr),
        .pos_out   (pos_nx)
    );

    assign last_chunk = (chunk_q == CHK_W'(N_CHUNKS - 1));

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // Transitions.
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:  if (fill_valid) nxt = S_SCAN;
            S_SCAN:  if (last_chunk) nxt = S_DONE;
            S_DONE:  nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    // Scan datapath.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chunk_q <= '0;
            pos_q   <= '0;
            line_q  <= '0;
            off_q   <= '0;
            start_q <= '0;
            end_q   <= '0;
            br_q    <= '0;
            type_q  <= '0;
            inc_q   <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: if (fill_valid) begin
                    line_q  <= fill_line;
                    off_q   <= fill_offset;
                    pos_q   <= {1'b0, fill_offset};
                    chunk_q <= '0;
                    start_q <= '0;
                    end_q   <= '0;
                    br_q    <= '0;
                    type_q  <= '0;
                    inc_q   <= 1'b0;
                end
                S_SCAN: begin
                    start_q <= start_q | s_set;
                    end_q   <= end_q | e_set;
                    br_q    <= br_q | b_set;
                    type_q  <= type_q | t_set;
                    inc_q   <= inc_q | ovr;
                    pos_q   <= pos_nx;
                    chunk_q <= chunk_q + CHK_W'(1);
                end
                default: ;
            endcase
        end
    end

    // Outputs.
    always_comb begin
        fill_done      = (state == S_DONE);
        ann_start      = start_q;
        ann_end        = end_q;
        ann_branch     = br_q;
        ann_btype      = type_q;
        ann_incomplete = inc_q;
    end

    logic [LINE_BYTES-1:0] low_mask;
    assign low_mask = (LINE_BYTES'(1) << off_q) - LINE_BYTES'(1);

    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fill_done |=> !fill_done);

    assert_done_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && fill_valid) |-> ##5 fill_done);

    assert_mark_balance_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fill_done |-> ($countones(ann_end) + int'(ann_incomplete) == $countones(ann_start)));

    assert_no_early_marks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fill_done |-> (((ann_start | ann_end) & low_mask) == '0));

    assert_branch_on_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fill_done |-> ((ann_branch & ~ann_start) == '0));
endmodule

// File: rtl/ilpd_extract.sv
module ilpd_extract
    import ilpd_pkg::*;
(
    input  logic [LINE_W-1:0]         line,
    input  logic [LINE_BYTES-1:0]     starts,
    input  logic [LINE_BYTES-1:0]     ends,
    input  logic [POS_W-1:0]          offset,
    output logic [N_SLOTS-1:0]        slot_valid,
    output logic [N_SLOTS*LEN_W-1:0]  slot_len,
    output logic [N_SLOTS*SLOT_W-1:0] slot_data
);
    int         cnt;
    logic       open;
    int         s;

    // Pair each start mark with the next end mark; no length decode.
    always_comb begin
        slot_valid = '0;
        slot_len   = '0;
        slot_data  = '0;
        cnt        = 0;
        open       = 1'b0;
        s          = 0;
        for (int i = 0; i < LINE_BYTES; i++) begin
            if (i >= int'(offset)) begin
                if (starts[i]) begin
                    open = 1'b1;
                    s    = i;
                end
                if (open && (i - s) >= MAX_LEN) open = 1'b0;
                if (ends[i] && open && cnt < N_SLOTS) begin
                    slot_valid[cnt] = 1'b1;
                    slot_len[cnt*LEN_W +: LEN_W] = LEN_W'(i - s + 1);
                    for (int k = 0; k < MAX_LEN; k++) begin
                        if (s + k <= i)
                            slot_data[cnt*SLOT_W + k*8 +: 8] = line[(s + k)*8 +: 8];
                    end
                    cnt  = cnt + 1;
                    open = 1'b0;
                end
            end
        end
    end

    always_comb begin
        assert_slots_packed_R10: assert ((slot_valid & (slot_valid + N_SLOTS'(1))) == '0)
            else $error("slot valid bits not packed");
        for (int k = 0; k < N_SLOTS; k++) begin
            assert_slot_len_R9: assert (!slot_valid[k] ||
                (slot_len[k*LEN_W +: LEN_W] >= LEN_W'(1) && slot_len[k*LEN_W +: LEN_W] <= LEN_W'(MAX_LEN)))
                else $error("slot length out of range");
        end
    end
endmodule

// File: rtl/ilen_predecode.sv
module ilen_predecode
    import ilpd_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        fill_valid,
    input  logic [LINE_W-1:0]           fill_line,
    input  logic [POS_W-1:0]            fill_offset,
    output logic                        fill_done,
    output logic [LINE_BYTES-1:0]       ann_start,
    output logic [LINE_BYTES-1:0]       ann_end,
    output logic [LINE_BYTES-1:0]       ann_branch,
    output logic [2*LINE_BYTES-1:0]     ann_btype,
    output logic                        ann_incomplete,
    input  logic [LINE_W-1:0]           fetch_line,
    input  logic [LINE_BYTES-1:0]       fetch_start,
    input  logic [LINE_BYTES-1:0]       fetch_end,
    input  logic [POS_W-1:0]            fetch_offset,
    output logic [N_SLOTS-1:0]          slot_valid,
    output logic [N_SLOTS*LEN_W-1:0]    slot_len,
    output logic [N_SLOTS*SLOT_W-1:0]   slot_data
);
    ilpd_fill_fsm u_fill (
        .clk            (clk),
        .rst_n          (rst_n),
        .fill_valid     (fill_valid),
        .fill_line      (fill_line),
        .fill_offset    (fill_offset),
        .fill_done      (fill_done),
        .ann_start      (ann_start),
        .ann_end        (ann_end),
        .ann_branch     (ann_branch),
        .ann_btype      (ann_btype),
        .ann_incomplete (ann_incomplete)
    );

    ilpd_extract u_extract (
        .line       (fetch_line),
        .starts     (fetch_start),
        .ends       (fetch_end),
        .offset     (fetch_offset),
        .slot_valid (slot_valid),
        .slot_len   (slot_len),
        .slot_data  (slot_data)
    );
endmodule

// File: tb/ilen_predecode_bench.sv
`timescale 1ns/1ps
module ilen_predecode_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         fill_valid = 1'b0;
    logic [127:0] fill_line = '0;
    logic [3:0]   fill_offset = '0;
    logic         fill_done;
    logic [15:0]  ann_start, ann_end, ann_branch;
    logic [31:0]  ann_btype;
    logic         ann_incomplete;
    logic [127:0] fetch_line = '0;
    logic [15:0]  fetch_start = '0, fetch_end = '0;
    logic [3:0]   fetch_offset = '0;
    logic [2:0]   slot_valid;
    logic [8:0]   slot_len;
    logic [95:0]  slot_data;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    ilen_predecode u_ilen_predecode (.*);

    task automatic chk(input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Expected annotation, walked byte by byte from the raw line.
    function automatic void model_fill(input logic [127:0] ln, input int off,
        output logic [15:0] st, output logic [15:0] en, output logic [15:0] br,
        output logic [31:0] ty, output logic inc);
        int p = off;
        st = '0; en = '0; br = '0; ty = '0; inc = 1'b0;
        while (p < 16) begin
            logic [7:0] b;
            int len;
            b   = ln[p*8 +: 8];
            len = int'(b[7:6]) + 1;
            st[p] = 1'b1;
            if (p + len - 1 <= 15) en[p + len - 1] = 1'b1;
            else inc = 1'b1;
            if (b[7:4] == 4'hE) begin
                br[p] = 1'b1;
                ty[p*2 +: 2] = b[1:0];
            end
            p = p + len;
        end
    endfunction

    task automatic check_ann(input string req, input logic [127:0] ln, input int off);
        logic [15:0] st, en, br;
        logic [31:0] ty;
        logic inc;
        model_fill(ln, off, st, en, br, ty, inc);
        chk("R4", {req, " start marks"}, ann_start, st);
        chk("R4", {req, " end marks"}, ann_end, en);
        chk("R7", {req, " branch flags"}, ann_branch, br);
        chk("R8", {req, " branch types"}, ann_btype, ty);
        chk("R6", {req, " incomplete"}, ann_incomplete, inc);
    endtask

    task automatic run_fill(input string req, input logic [127:0] ln, input int off);
        @(negedge clk);
        fill_valid = 1'b1; fill_line = ln; fill_offset = 4'(off);
        @(negedge clk);
        fill_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk("R2", {req, " done early"}, fill_done, 1'b0);
        @(negedge clk);
        chk("R2", {req, " done on time"}, fill_done, 1'b1);
        check_ann(req, ln, off);
        @(negedge clk);
        chk("R2", {req, " done one cycle"}, fill_done, 1'b0);
    endtask

    task automatic check_fetch(input string req, input logic [127:0] ln,
                               input int fill_off, input int f_off);
        logic [2:0]  ev;
        logic [8:0]  el;
        logic [95:0] ed;
        int p, cnt;
        ev = '0; el = '0; ed = '0; p = fill_off; cnt = 0;
        while (p < 16) begin
            int len;
            len = int'(ln[p*8 + 6 +: 2]) + 1;
            if (p >= f_off && p + len - 1 <= 15 && cnt < 3) begin
                ev[cnt] = 1'b1;
                el[cnt*3 +: 3] = 3'(len);
                for (int k = 0; k < len; k++) ed[cnt*32 + k*8 +: 8] = ln[(p + k)*8 +: 8];
                cnt++;
            end
            p = p + len;
        end
        @(negedge clk);
        fetch_line = ln; fetch_start = ann_start; fetch_end = ann_end;
        fetch_offset = 4'(f_off);
        #1;
        chk("R10", {req, " slot valid"}, slot_valid, ev);
        chk("R9", {req, " slot len"}, slot_len, el);
        chk("R9", {req, " slot data"}, slot_data, ed);
    endtask

    // Lines, byte 0 in the low bits.
    localparam logic [127:0] L_ONE   = 128'h100F0E0D0C0B0A090807060504030201;
    // 0:40(2) 2:81(3) 5:E0(4) 9:E1(4) 13:05(1) 14:42(2)
    localparam logic [127:0] L_MIX   = 128'h004205FFFFFFE1FFFFFFE0FFFF81FF40;
    // 0:E2 call 4:E3 ret 8:C7 plain 12:EF ret
    localparam logic [127:0] L_CALL  = 128'h000000EF000000C7000000E3000000E2;
    // 0:C0 4:C0 8:C0 12:80(3) 15:E0 overruns
    localparam logic [127:0] L_TAIL  = 128'hE0000080000000C0000000C0000000C0;

    task automatic t_reset();
        chk("R1", "reset done", fill_done, 1'b0);
        chk("R1", "reset marks", {ann_start, ann_end, ann_branch}, '0);
        chk("R1", "reset types", {ann_btype, ann_incomplete}, '0);
    endtask

    task automatic t_single_bytes();
        run_fill("R4 one-byte", L_ONE, 0);
        check_fetch("R9 one-byte", L_ONE, 0, 0);
    endtask

    task automatic t_mixed();
        run_fill("R4 R7 mixed", L_MIX, 0);
        check_fetch("R9 mixed", L_MIX, 0, 0);
        check_fetch("R9 mixed mid", L_MIX, 0, 9);
    endtask

    task automatic t_branch_classes();
        run_fill("R8 classes", L_CALL, 0);
        chk("R8", "call class", ann_btype[1:0], 2'b10);
        chk("R8", "return class", ann_btype[9:8], 2'b11);
        chk("R7", "plain not branch", ann_branch[8], 1'b0);
        check_fetch("R10 classes", L_CALL, 0, 4);
    endtask

    task automatic t_offset();
        run_fill("R5 offset", L_MIX, 2);
        chk("R5", "no marks below offset", {ann_start[1:0], ann_end[1:0]}, 4'b0);
        check_fetch("R9 offset", L_MIX, 2, 2);
    endtask

    task automatic t_tail();
        run_fill("R6 tail", L_TAIL, 0);
        chk("R6", "tail start", ann_start[15], 1'b1);
        chk("R6", "tail flag", ann_incomplete, 1'b1);
        check_fetch("R10 tail", L_TAIL, 0, 12);
        check_fetch("R10 tail only", L_TAIL, 0, 15);
    endtask

    task automatic t_busy();
        @(negedge clk);
        fill_valid = 1'b1; fill_line = L_CALL; fill_offset = 4'd0;
        @(negedge clk);
        fill_line = L_ONE; fill_offset = 4'd5;
        repeat (3) @(negedge clk);
        chk("R3", "busy done early", fill_done, 1'b0);
        @(negedge clk);
        chk("R3", "busy done on time", fill_done, 1'b1);
        fill_valid = 1'b0;
        check_ann("R3 busy", L_CALL, 0);
        for (int c = 0; c < 8; c++) begin
            @(negedge clk);
            chk("R3", "no extra done", fill_done, 1'b0);
        end
        check_ann("R3 busy hold", L_CALL, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single_bytes();
        t_mixed();
        t_branch_classes();
        t_offset();
        t_tail();
        t_busy();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule